// File: doc/BRIEF.md
# Phase-Staggered Four-Channel Dimming PWM

This block generates four pulse-width-modulated dimming signals from one shared, free-running 13-bit period counter. The counter spans 8192 clocks. Each channel's pulse begins at a fixed phase offset, so the four loads switch on at four evenly spaced points in the period instead of all at count zero. This spreads the current drawn from a shared supply across the period.

Software-facing logic writes a duty word and a channel select with a single strobe. The block turns the duty into a set point, a clear point and a polarity bit, and holds them in a shadow copy. If the pulse would run past the end of the period, it wraps round: the two points are swapped in role and the output sense is inverted, so the on-time stays exact at any offset. The shadow copy becomes active only when the counter passes from 8191 back to 0. A new duty therefore never cuts or stretches the pulse in flight, and the counter is never halted. Every channel drives two output pins that carry the same waveform.

Top module: `staggerPwm`

## Requirements
- R1: The period counter runs freely from 0 to 8191 and then returns to 0, so every output repeats every 8192 clocks. The outputs are registered: the level that belongs to counter value c appears one clock after the counter holds c. In the first clock after reset is released, the counter holds 0.
- R2: Channel i (i = 0..3) has a phase offset of i*1024 counts. For any duty from 1 to 8191, the channel's single rising edge per period falls at count i*1024.
- R3: When duty plus offset is at most 8192, the output is high for counts offset through offset+duty-1 and low elsewhere. A sum of exactly 8192 belongs to this case.
- R4: When duty plus offset exceeds 8192, the set point becomes duty+offset-8192, the clear point becomes the offset, and the polarity is inverted. The output is then high for counts below the set point and for counts from the offset up to 8191. Its high time equals the duty and its rising edge stays at the offset.
- R5: A duty of 0 holds the output low for the whole period, with no one-clock pulse at the offset.
- R6: A duty of 8192 holds the output high for the whole period at every offset. A duty word above 8192 is treated as 8192.
- R7: A channel select above 3 writes channel 3. The other channels keep their settings.
- R8: A write only updates the shadow setting. The running period completes with the old setting, and the new one takes effect from count 0 of the next period.
- R9: The two pins of a channel (`pwmA[i]`, `pwmB[i]`) carry identical waveforms at all times.
- R10: While reset is asserted, and in the first output cycle after it is released, all outputs are low. Reset sets every duty to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one counter step per cycle |
| rstN | input | 1 | Synchronous reset, active low |
| wrEn | input | 1 | Write strobe for one duty word |
| wrSel | input | 3 | Channel select; values above 3 address channel 3 |
| wrDuty | input | 14 | Duty in counts, 0..8192 (larger values saturate) |
| pwmA | output | 4 | First output pin of each channel |
| pwmB | output | 4 | Second output pin of each channel, same waveform as pwmA |

## Verification
All four channels are programmed together with several duty patterns:
- equal mid-range duties, which show the pure offset staggering;
- mixes where some channels wrap past the period end and others do not, which separate the normal and inverted compare paths;
- the 0 and 8192 extremes, together with sums that land exactly on 8192, which expose off-by-one errors in the wrap test.

Each period is sampled in full, and the high time and rising-edge position of every channel are compared with the duty and the offset. Directed tests write a new duty partway through a period, to show that the old pulse still completes. They also issue an out-of-range select and an oversized duty, to show that the select clamps, the duty saturates and the other channels are left alone.

// File: rtl/staggerPwmPkg.sv
package staggerPwmPkg;

  // Output sense of a channel: normal drives high inside [set, clear),
  // inverted drives high outside it (used when the pulse wraps).
  typedef enum logic {
    POL_NORMAL = 1'b0,
    POL_INVERT = 1'b1
  } pwmPol_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic commit;   // copy shadow settings into the active set this cycle
  } pwmStrobe_t;

endpackage

// File: rtl/staggerPwmControl.sv
module staggerPwmControl
  import staggerPwmPkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int CNT_W      = 13,
  parameter int PHASE_STEP = 1024,
  parameter int SEL_W      = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrEn,
  input  logic [SEL_W-1:0]              wrSel,
  input  logic [CNT_W:0]                wrDuty,
  input  logic                          cntLast,
  output pwmStrobe_t                    strobe,
  output logic [NUM_CH-1:0][CNT_W:0]    shSet,
  output logic [NUM_CH-1:0][CNT_W:0]    shClr,
  output logic [NUM_CH-1:0]             shPol
);

  localparam int CMP_W = CNT_W + 1;
  localparam int SUM_W = CNT_W + 2;
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [SUM_W-1:0] PERIOD  = {2'b01, {CNT_W{1'b0}}};
  localparam logic [SEL_W-1:0] MAX_SEL = SEL_W'(NUM_CH - 1);

  logic [IDX_W-1:0] chIdx;
  logic [SUM_W-1:0] dutySat;
  logic [SUM_W-1:0] offset;
  logic [SUM_W-1:0] sum;
  logic [CMP_W-1:0] newSet;
  logic [CMP_W-1:0] newClr;
  pwmPol_e          newPol;
  logic             pending;

  // Clamp the select and the duty, then place the pulse relative to the offset.
  always_comb begin
    chIdx   = (wrSel > MAX_SEL) ? IDX_W'(NUM_CH - 1) : IDX_W'(wrSel);
    dutySat = ({1'b0, wrDuty} > PERIOD) ? PERIOD : {1'b0, wrDuty};
    offset  = SUM_W'(chIdx) * SUM_W'(PHASE_STEP);
    sum     = dutySat + offset;
    if (sum > PERIOD) begin
      // Pulse crosses the period end: the wrapped tail starts the window,
      // the offset closes it, and the sense is inverted.
      newSet = CMP_W'(sum - PERIOD);
      newClr = CMP_W'(offset);
      newPol = POL_INVERT;
    end else begin
      newSet = CMP_W'(offset);
      newClr = CMP_W'(sum);
      newPol = POL_NORMAL;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_shadow
    always_ff @(posedge clk) begin
      if (!rstN) begin
        shSet[i] <= CMP_W'(i * PHASE_STEP);
        shClr[i] <= CMP_W'(i * PHASE_STEP);
        shPol[i] <= POL_NORMAL;
      end else if (wrEn && (chIdx == IDX_W'(i))) begin
        shSet[i] <= newSet;
        shClr[i] <= newClr;
        shPol[i] <= newPol;
      end
    end
  end

  // A write arms one commit at the next period end. A write landing on
  // that same edge stays armed for the following boundary.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (wrEn) begin
      pending <= 1'b1;
    end else if (cntLast) begin
      pending <= 1'b0;
    end
  end

  assign strobe.commit = cntLast && pending;

endmodule

// File: rtl/staggerPwmDatapath.sv
module staggerPwmDatapath
  import staggerPwmPkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 13
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  pwmStrobe_t                    strobe,
  input  logic [NUM_CH-1:0][CNT_W:0]    shSet,
  input  logic [NUM_CH-1:0][CNT_W:0]    shClr,
  input  logic [NUM_CH-1:0]             shPol,
  output logic [CNT_W-1:0]              cntQ,
  output logic                          cntLast,
  output logic [NUM_CH-1:0][CNT_W:0]    actSet,
  output logic [NUM_CH-1:0][CNT_W:0]    actClr,
  output logic [NUM_CH-1:0]             actPol,
  output logic [NUM_CH-1:0]             pwmA,
  output logic [NUM_CH-1:0]             pwmB
);

  localparam int CMP_W = CNT_W + 1;

  // Free-running period counter; the natural binary rollover is the wrap.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
    end else begin
      cntQ <= cntQ + 1'b1;
    end
  end

  assign cntLast = (cntQ == {CNT_W{1'b1}});

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    logic inWin;
    logic level;

    always_comb begin
      inWin = ({1'b0, cntQ} >= actSet[i]) && ({1'b0, cntQ} < actClr[i]);
      level = (actPol[i] == POL_INVERT) ? !inWin : inWin;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        actSet[i] <= '0;
        actClr[i] <= '0;
        actPol[i] <= POL_NORMAL;
      end else if (strobe.commit) begin
        actSet[i] <= shSet[i];
        actClr[i] <= shClr[i];
        actPol[i] <= shPol[i];
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pwmA[i] <= 1'b0;
        pwmB[i] <= 1'b0;
      end else begin
        pwmA[i] <= level;
        pwmB[i] <= level;
      end
    end
  end

  logic unusedWidth;
  assign unusedWidth = (CMP_W == 0);

endmodule

// File: rtl/staggerPwm.sv
module staggerPwm
  import staggerPwmPkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int CNT_W      = 13,
  parameter int PHASE_STEP = 1024,
  parameter int SEL_W      = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [CNT_W:0]    wrDuty,
  output logic [NUM_CH-1:0] pwmA,
  output logic [NUM_CH-1:0] pwmB
);

  pwmStrobe_t                  strobe;
  logic                        cntLast;
  logic [CNT_W-1:0]            cntQ;
  logic [NUM_CH-1:0][CNT_W:0]  shSet;
  logic [NUM_CH-1:0][CNT_W:0]  shClr;
  logic [NUM_CH-1:0]           shPol;
  logic [NUM_CH-1:0][CNT_W:0]  actSet;
  logic [NUM_CH-1:0][CNT_W:0]  actClr;
  logic [NUM_CH-1:0]           actPol;

  staggerPwmControl #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .PHASE_STEP(PHASE_STEP), .SEL_W(SEL_W)
  ) u_control (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrDuty(wrDuty),
    .cntLast(cntLast), .strobe(strobe),
    .shSet(shSet), .shClr(shClr), .shPol(shPol)
  );

  staggerPwmDatapath #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .shSet(shSet), .shClr(shClr), .shPol(shPol),
    .cntQ(cntQ), .cntLast(cntLast),
    .actSet(actSet), .actClr(actClr), .actPol(actPol),
    .pwmA(pwmA), .pwmB(pwmB)
  );

endmodule

// File: rtl/staggerPwmChecker.sv
module staggerPwmChecker #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 13
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [CNT_W-1:0]              cntQ,
  input logic [NUM_CH-1:0][CNT_W:0]    actSet,
  input logic [NUM_CH-1:0][CNT_W:0]    actClr,
  input logic [NUM_CH-1:0]             actPol,
  input logic [NUM_CH-1:0]             pwmA,
  input logic [NUM_CH-1:0]             pwmB
);

  localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}};

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cntQ != LAST) |=> (cntQ == $past(cntQ) + 1'b1));

  // R1
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cntQ == LAST) |=> (cntQ == '0));

  // R8
  act_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cntQ != LAST) |=> ($stable(actSet) && $stable(actClr) && $stable(actPol)));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    // R5
    zero_low_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!actPol[i] && (actSet[i] == actClr[i])) |=> (!pwmA[i] && !pwmB[i]));

    // R6
    full_high_chk: assert property (@(posedge clk) disable iff (!rstN)
      (actPol[i] && (actSet[i] == actClr[i])) |=> (pwmA[i] && pwmB[i]));

    // R3
    set_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!actPol[i] && (actSet[i] < actClr[i]) && ({1'b0, cntQ} == actSet[i]))
      |=> (pwmA[i] && pwmB[i]));
  end

endmodule

bind staggerPwm staggerPwmChecker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .cntQ(cntQ),
  .actSet(actSet), .actClr(actClr), .actPol(actPol),
  .pwmA(pwmA), .pwmB(pwmB)
);

// File: tb/staggerPwm_bench.sv
module staggerPwm_bench;

  localparam int PER  = 8192;
  localparam int STEP = 1024;
  localparam int NVEC = 6;

  // Duties per channel and expected rising-edge count (-1: no edge).
  localparam int VEC_DUTY [NVEC][4] = '{
    '{0,    0,    0,    0   },
    '{4096, 4096, 4096, 4096},
    '{8192, 8192, 8192, 8192},
    '{7000, 6000, 7000, 5500},
    '{1,    8191, 5120, 5121},
    '{4096, 2048, 6144, 5120}
  };
  localparam int VEC_RISE [NVEC][4] = '{
    '{-1, -1,   -1,   -1  },
    '{0,  1024, 2048, 3072},
    '{-1, -1,   -1,   -1  },
    '{0,  1024, 2048, 3072},
    '{0,  1024, 2048, 3072},
    '{0,  1024, 2048, 3072}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrSel = '0;
  logic [13:0] wrDuty = '0;
  logic [3:0] pwmA;
  logic [3:0] pwmB;

  int nChecks = 0;
  int nFail = 0;
  int bCnt = 0;
  int mHi [4];
  int mRise [4];
  int mPin;
  logic [3:0] firstS;
  logic [3:0] prevS;

  staggerPwm u_staggerPwm (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrDuty(wrDuty),
    .pwmA(pwmA), .pwmB(pwmB)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) bCnt <= 0;
    else       bCnt <= bCnt + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic writeDuty(input int sel, input int duty);
    @(negedge clk);
    wrEn = 1'b1;
    wrSel = 3'(sel);
    wrDuty = 14'(duty);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Advance to the negedge whose output belongs to counter value 0.
  task automatic waitStart();
    @(negedge clk);
    while (bCnt == 0 || ((bCnt - 1) % PER) != 0) @(negedge clk);
  endtask

  task automatic measure();
    waitStart();
    mPin = 0;
    for (int ch = 0; ch < 4; ch++) begin
      mHi[ch] = 0;
      mRise[ch] = -1;
    end
    for (int k = 0; k < PER; k++) begin
      if (k > 0) @(negedge clk);
      if (pwmA !== pwmB) mPin++;
      for (int ch = 0; ch < 4; ch++) begin
        if (pwmA[ch]) mHi[ch]++;
        if (k > 0 && pwmA[ch] && !prevS[ch] && mRise[ch] < 0) mRise[ch] = k;
      end
      if (k == 0) firstS = pwmA;
      prevS = pwmA;
    end
    for (int ch = 0; ch < 4; ch++)
      if (mRise[ch] < 0 && firstS[ch] && !prevS[ch]) mRise[ch] = 0;
  endtask

  function automatic string hiTag(input int ch, input int duty);
    if (duty == 0) return "R5";
    if (duty >= PER) return "R6";
    if (duty + ch * STEP > PER) return "R4";
    return "R3";
  endfunction

  initial begin
    logic pr;
    int cyc;

    // R10: reset holds outputs low.
    repeat (4) @(negedge clk);
    check(pwmA == 4'b0 && pwmB == 4'b0, "R10 in reset", int'(pwmA), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(pwmA == 4'b0 && pwmB == 4'b0, "R10 after release", int'(pwmA), 0);

    for (int v = 0; v < NVEC; v++) begin
      for (int ch = 0; ch < 4; ch++) writeDuty(ch, VEC_DUTY[v][ch]);
      measure();
      for (int ch = 0; ch < 4; ch++) begin
        check(mHi[ch] == VEC_DUTY[v][ch], hiTag(ch, VEC_DUTY[v][ch]), mHi[ch], VEC_DUTY[v][ch]);
        check(mRise[ch] == VEC_RISE[v][ch], "R2 rise position", mRise[ch], VEC_RISE[v][ch]);
      end
      check(mPin == 0, "R9 pin mismatch cycles", mPin, 0);

      if (v == 1) begin
        // R1: rise-to-rise distance on channel 1 equals the period.
        pr = pwmA[1];
        @(negedge clk);
        while (!(pwmA[1] && !pr)) begin pr = pwmA[1]; @(negedge clk); end
        check(((bCnt - 1) % PER) == STEP, "R1 rise count", (bCnt - 1) % PER, STEP);
        pr = pwmA[1];
        @(negedge clk);
        cyc = 1;
        while (!(pwmA[1] && !pr)) begin pr = pwmA[1]; @(negedge clk); cyc++; end
        check(cyc == PER, "R1 period", cyc, PER);
      end
    end

    // R8: write channel 0 to zero partway through a period with duty 4096.
    fork
      measure();
      begin
        repeat (100) @(negedge clk);
        writeDuty(0, 0);
      end
    join
    check(mHi[0] == 4096, "R8 old pulse completes", mHi[0], 4096);
    check(mRise[0] == 0, "R8 old rise kept", mRise[0], 0);
    measure();
    check(mHi[0] == 0, "R8 new duty next period", mHi[0], 0);
    check(mRise[0] == -1, "R8 no rise after update", mRise[0], -1);

    // R7 and R6: select 6 maps to channel 3, duty 12000 saturates.
    writeDuty(6, 12000);
    measure();
    check(mHi[3] == PER, "R6 saturated duty", mHi[3], PER);
    check(mRise[3] == -1, "R7 clamped channel no edge", mRise[3], -1);
    check(mHi[0] == 0, "R7 channel 0 unchanged", mHi[0], 0);
    check(mHi[1] == 2048, "R7 channel 1 unchanged", mHi[1], 2048);
    check(mHi[2] == 6144, "R7 channel 2 unchanged", mHi[2], 6144);
    check(mPin == 0, "R9 pins after clamp", mPin, 0);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule